// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits beside the pad logic of a 32-bit multiplexed address/data bus that also carries four active-low command/byte-enable lines. It looks at the values on the bus in every address or data phase. When the block itself drives the bus, it computes the even-parity bit for that phase and presents it one clock later, with its own output enable. When another agent drives the bus, it compares the parity bit received one clock later against its own calculation.

A mismatch on a data phase pulls the active-low parity-error output low for one clock. A mismatch on an address phase pulls the active-low system-error output low for one clock, but only when the system-error enable is set. Either kind of mismatch sets a sticky detected-parity-error status bit. Software owns the register that holds this bit as its most significant bit, and a write-one-to-clear pulse clears it.

Both error outputs go low two clocks after the phase that caused them. The initiator parity lags its phase by exactly one clock.

Top module: `bus_parity_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, `perr_n_o` and `serr_n_o` are 1, `par_oe_o` is 0 (parity pin not driven), `par_o` is 0 and `detected_perr_o` is 0.
- R2: In the cycle after a phase in which `ad_oe_i` is 1, `par_o` equals the XOR of all 32 AD bits and all 4 C/BE# bits. The count of ones across AD, C/BE# and the parity bit is therefore even.
- R3: `par_oe_o` equals `ad_oe_i` delayed by one clock.
- R4: A data phase (`data_phase_i`=1) with `ad_oe_i`=0 whose `par_i`, sampled one clock later, differs from the even parity of that phase drives `perr_n_o` low in the cycle two clocks after the phase, for exactly one clock. A matching `par_i` leaves `perr_n_o` high.
- R5: An address phase (`addr_phase_i`=1) with `ad_oe_i`=0 and a mismatching `par_i` one clock later drives `serr_n_o` low for exactly one clock, two clocks after the phase, when `serr_en_i` is 1 in the cycle `par_i` is sampled.
- R6: With `serr_en_i`=0 in that cycle, an address parity mismatch leaves `serr_n_o` high.
- R7: Address mismatches never drive `perr_n_o` low, and data mismatches never drive `serr_n_o` low.
- R8: Any address or data mismatch sets `detected_perr_o` to 1, whatever the value of `serr_en_i`. The bit stays 1 after the error pulse ends.
- R9: A one-clock pulse on `stat_clr_i` clears `detected_perr_o` in the next cycle. When a new mismatch is registered in the same clock as the clear, the bit stays 1.
- R10: Phases in which `ad_oe_i` is 1 are never checked: a wrong `par_i` afterwards produces no error and sets no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 32 | Value on the address/data lines this cycle |
| cbe_n_i | input | 4 | Value on the command/byte-enable lines this cycle |
| addr_phase_i | input | 1 | This cycle is a valid address phase |
| data_phase_i | input | 1 | This cycle is a valid data phase |
| ad_oe_i | input | 1 | Block drives AD this cycle (1) or receives it (0) |
| par_i | input | 1 | Parity bit sampled from the bus |
| serr_en_i | input | 1 | Configuration enable for system-error reporting |
| stat_clr_i | input | 1 | Write-one-to-clear pulse for the status bit |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity pin |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_n_o | output | 1 | Address parity error, active low |
| detected_perr_o | output | 1 | Sticky detected-parity-error status |

## Verification
The assertions assume that a cycle is never both an address phase and a data phase. They also assume that `par_i` in the cycle after a received phase is the value the sending agent put on the bus. The bench drives a single phase at a time and places a strobe in at most one phase per sequence. It supplies `par_i` from its own arithmetic parity, flipped only when a case asks for an error. This keeps every error pulse traceable to one phase two clocks earlier, which is what the checker relies on.

// File: rtl/bpar_pkg.sv
// Package: shared types for the bus parity unit.
// Assumes an address or data phase is one bus cycle wide.
package bpar_pkg;

    // Work carried from a sampled phase into the cycle where its parity arrives
    typedef struct packed {
        logic chk_addr;   // received address phase awaits its parity
        logic chk_data;   // received data phase awaits its parity
        logic calc;       // parity computed from AD and C/BE#
    } chk_stage_t;

endpackage

// File: rtl/lane_parity.sv
// lane_parity: combinational even-parity over the bus. Each byte lane is
// reduced with its own C/BE# line, and the lane results are combined.
// Assumes DATA_W is a whole multiple of BE_W.
module lane_parity #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_n_i,
    output logic              par_o
);
    localparam int LANE_W = DATA_W / BE_W;

    logic [BE_W-1:0] lane_par;

    // One reduction per byte lane, folding in that lane's enable line
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_n_i[g];
    end

    // Combine the lane results into the bus parity
    assign par_o = ^lane_par;

endmodule

// File: rtl/par_gen.sv
// par_gen: initiator side. Registers the computed parity and the AD output
// enable, so that the parity pin is valid and driven one clock after the phase.
// Assumes calc_i is the parity of the value this block puts on the bus.
module par_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic calc_i,
    input  logic ad_oe_i,
    output logic par_o,
    output logic par_oe_o
);
    // One-clock delay for parity and its enable; idle is undriven
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_o    <= 1'b0;
            par_oe_o <= 1'b0;
        end else begin
            par_o    <= ad_oe_i ? calc_i : 1'b0;
            par_oe_o <= ad_oe_i;
        end
    end

endmodule

// File: rtl/par_chk.sv
// par_chk: target side. Remembers each received phase and its computed
// parity for one clock, then compares them with the parity pin sampled then.
// Assumes address and data strobes are never set in the same cycle.
module par_chk
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic calc_i,
    input  logic addr_phase_i,
    input  logic data_phase_i,
    input  logic ad_oe_i,
    input  logic par_i,
    output logic addr_err_o,
    output logic data_err_o
);
    chk_stage_t stage_q;
    logic       mismatch;

    // Capture received phases only; driven phases are ours and not checked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q.chk_addr <= addr_phase_i & ~ad_oe_i;
            stage_q.chk_data <= data_phase_i & ~ad_oe_i;
            stage_q.calc     <= calc_i;
        end
    end

    // Compare the arriving parity bit with the remembered calculation
    always_comb begin
        mismatch   = par_i ^ stage_q.calc;
        addr_err_o = stage_q.chk_addr & mismatch;
        data_err_o = stage_q.chk_data & mismatch;
    end

endmodule

// File: rtl/err_report.sv
// err_report: turns mismatches into one-clock active-low pulses and keeps
// the sticky status bit. Address errors reach the system-error line only
// when enabled; every error sets the status bit, and setting wins over a clear.
module err_report (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_err_i,
    input  logic data_err_i,
    input  logic serr_en_i,
    input  logic stat_clr_i,
    output logic perr_n_o,
    output logic serr_n_o,
    output logic detected_o
);
    // Registered one-clock error strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_n_o <= 1'b1;
            serr_n_o <= 1'b1;
        end else begin
            perr_n_o <= ~data_err_i;
            serr_n_o <= ~(addr_err_i & serr_en_i);
        end
    end

    // Sticky status: set by any error, cleared by write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            detected_o <= 1'b0;
        end else if (addr_err_i | data_err_i) begin
            detected_o <= 1'b1;
        end else if (stat_clr_i) begin
            detected_o <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_parity_unit.sv
// bus_parity_unit: parity generation and checking for a multiplexed
// address/data bus. PAR follows its phase by one clock, error strobes follow
// by two. Assumes the caller qualifies phases with the strobes and ad_oe_i.
module bus_parity_unit #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_n_i,
    input  logic              addr_phase_i,
    input  logic              data_phase_i,
    input  logic              ad_oe_i,
    input  logic              par_i,
    input  logic              serr_en_i,
    input  logic              stat_clr_i,
    output logic              par_o,
    output logic              par_oe_o,
    output logic              perr_n_o,
    output logic              serr_n_o,
    output logic              detected_perr_o
);
    logic calc;
    logic addr_err;
    logic data_err;

    // Parity of the current bus value
    lane_parity #(.DATA_W(DATA_W), .BE_W(BE_W)) u_tree (
        .ad_i    (ad_i),
        .cbe_n_i (cbe_n_i),
        .par_o   (calc)
    );

    // Initiator parity output
    par_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .calc_i   (calc),
        .ad_oe_i  (ad_oe_i),
        .par_o    (par_o),
        .par_oe_o (par_oe_o)
    );

    // Target parity comparison
    par_chk u_chk_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .calc_i       (calc),
        .addr_phase_i (addr_phase_i),
        .data_phase_i (data_phase_i),
        .ad_oe_i      (ad_oe_i),
        .par_i        (par_i),
        .addr_err_o   (addr_err),
        .data_err_o   (data_err)
    );

    // Error strobes and status
    err_report u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_err_i (addr_err),
        .data_err_i (data_err),
        .serr_en_i  (serr_en_i),
        .stat_clr_i (stat_clr_i),
        .perr_n_o   (perr_n_o),
        .serr_n_o   (serr_n_o),
        .detected_o (detected_perr_o)
    );

endmodule

// File: rtl/bus_parity_unit_chk.sv
// bus_parity_unit_chk: timing properties of the parity unit, bound to it.
// A small counter of cycles since reset keeps $past looks within reset-free history.
module bus_parity_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_phase_i,
    input logic data_phase_i,
    input logic ad_oe_i,
    input logic serr_en_i,
    input logic stat_clr_i,
    input logic par_oe_o,
    input logic perr_n_o,
    input logic serr_n_o,
    input logic detected_perr_o
);
    logic [1:0] warm;

    // Count clocks since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R1: first cycle out of reset shows idle outputs
    always_ff @(posedge clk) begin
        if (rst_n && warm == 2'd0) begin
            r1_idle_chk: assert (perr_n_o && serr_n_o && !par_oe_o && !detected_perr_o)
                else $error("R1 outputs not idle after reset");
        end
    end

    // input assumption: one phase kind per cycle
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_phase_i, data_phase_i}));

    // R3
    par_oe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0) |-> (par_oe_o == $past(ad_oe_i)));

    // R4
    perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && !perr_n_o) |-> ($past(data_phase_i, 2) && !$past(ad_oe_i, 2)));

    // R7
    serr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && !serr_n_o) |-> ($past(addr_phase_i, 2) && !$past(ad_oe_i, 2)));

    // R6
    serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !serr_n_o) |-> $past(serr_en_i));

    // R8
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n_o || !serr_n_o) |-> detected_perr_o);

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && $fell(detected_perr_o)) |-> $past(stat_clr_i));

endmodule

bind bus_parity_unit bus_parity_unit_chk u_prop (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_phase_i    (addr_phase_i),
    .data_phase_i    (data_phase_i),
    .ad_oe_i         (ad_oe_i),
    .serr_en_i       (serr_en_i),
    .stat_clr_i      (stat_clr_i),
    .par_oe_o        (par_oe_o),
    .perr_n_o        (perr_n_o),
    .serr_n_o        (serr_n_o),
    .detected_perr_o (detected_perr_o)
);

// File: tb/sim_bus_parity_unit.sv
// Self-checking bench: sweeps bus patterns through initiator and target
// phases and predicts parity arithmetically.
module sim_bus_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_n_i = '0;
    logic        addr_phase_i = 1'b0;
    logic        data_phase_i = 1'b0;
    logic        ad_oe_i = 1'b0;
    logic        par_i = 1'b0;
    logic        serr_en_i = 1'b0;
    logic        stat_clr_i = 1'b0;
    logic        par_o, par_oe_o, perr_n_o, serr_n_o, detected_perr_o;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;
    logic det_exp = 1'b0;

    always #10 clk = ~clk;

    bus_parity_unit u0 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
        .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i),
        .ad_oe_i(ad_oe_i), .par_i(par_i), .serr_en_i(serr_en_i),
        .stat_clr_i(stat_clr_i), .par_o(par_o), .par_oe_o(par_oe_o),
        .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
        .detected_perr_o(detected_perr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Count ones arithmetically to obtain even parity
    function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(a[i]);
        for (int i = 0; i < 4; i++) n += int'(c[i]);
        return logic'(n % 2);
    endfunction

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    // One phase: kind 1 = address, 0 = data; oe = block drives; bad = flip par_i
    task automatic phase(input bit is_addr, input bit oe, input logic [31:0] a,
                         input logic [3:0] c, input bit bad, input bit en, input bit clr);
        logic p;
        bit   e_perr, e_serr;
        p = even_par(a, c);
        @(negedge clk);
        ad_i = a; cbe_n_i = c; ad_oe_i = oe;
        addr_phase_i = is_addr; data_phase_i = !is_addr;
        @(posedge clk);
        @(negedge clk);
        chk("R3 par_oe", {31'd0, par_oe_o}, {31'd0, oe});
        if (oe) chk("R2 par", {31'd0, par_o}, {31'd0, p});
        addr_phase_i = 1'b0; data_phase_i = 1'b0; ad_oe_i = 1'b0;
        par_i = p ^ bad; serr_en_i = en; stat_clr_i = clr;
        e_perr = !oe && !is_addr && bad;
        e_serr = !oe && is_addr && bad && en;
        if (!oe && bad) det_exp = 1'b1;
        else if (clr) det_exp = 1'b0;
        @(posedge clk);
        @(negedge clk);
        stat_clr_i = 1'b0;
        if (oe) chk("R10 perr", {31'd0, perr_n_o}, 32'd1);
        else if (is_addr) chk("R7 perr", {31'd0, perr_n_o}, 32'd1);
        else chk("R4 perr", {31'd0, perr_n_o}, {31'd0, !e_perr});
        if (is_addr && !en) chk("R6 serr", {31'd0, serr_n_o}, 32'd1);
        else if (is_addr) chk("R5 serr", {31'd0, serr_n_o}, {31'd0, !e_serr});
        else chk("R7 serr", {31'd0, serr_n_o}, 32'd1);
        chk(clr ? "R9 status" : "R8 status", {31'd0, detected_perr_o}, {31'd0, det_exp});
        @(posedge clk);
        @(negedge clk);
        chk("R4 perr width", {31'd0, perr_n_o}, 32'd1);
        chk("R5 serr width", {31'd0, serr_n_o}, 32'd1);
        chk("R8 sticky", {31'd0, detected_perr_o}, {31'd0, det_exp});
    endtask

    task automatic clear_status();
        @(negedge clk);
        stat_clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_clr_i = 1'b0;
        det_exp = 1'b0;
        chk("R9 clear", {31'd0, detected_perr_o}, 32'd0);
    endtask

    initial begin
        logic [31:0] x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 perr", {31'd0, perr_n_o}, 32'd1);
        chk("R1 serr", {31'd0, serr_n_o}, 32'd1);
        chk("R1 par_oe", {31'd0, par_oe_o}, 32'd0);
        chk("R1 par", {31'd0, par_o}, 32'd0);
        chk("R1 status", {31'd0, detected_perr_o}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 idle after release", {28'd0, perr_n_o, serr_n_o, par_oe_o, detected_perr_o}, 32'hC);

        // R2 / R10: initiator walking-one over AD, every C/BE# value
        for (int i = 0; i < 32; i++)
            phase(i[0], 1'b1, 32'd1 << i, i[3:0], 1'b1, 1'b1, 1'b0);
        for (int c = 0; c < 16; c++)
            phase(1'b0, 1'b1, 32'hFFFF_FFFF, c[3:0], 1'b0, 1'b0, 1'b0);
        chk("R10 no status", {31'd0, detected_perr_o}, 32'd0);

        // R4: received data phases, good and bad parity
        x = 32'hACE1_1234;
        for (int i = 0; i < 40; i++) begin
            x = lfsr(x);
            phase(1'b0, 1'b0, x, x[7:4], i[0], 1'b1, 1'b0);
        end
        clear_status();

        // R5 / R6: received address phases with enable on and off
        for (int i = 0; i < 32; i++) begin
            x = lfsr(x);
            phase(1'b1, 1'b0, x, x[3:0], i[0], i[1], 1'b0);
        end
        clear_status();

        // R6 alone still records the error
        phase(1'b1, 1'b0, 32'h0F0F_0F0F, 4'h5, 1'b1, 1'b0, 1'b0);
        chk("R6 status set", {31'd0, detected_perr_o}, 32'd1);

        // R9: clear coinciding with a new error keeps the bit
        phase(1'b0, 1'b0, 32'h1357_9BDF, 4'hA, 1'b1, 1'b1, 1'b1);
        // R9: plain clear with a clean phase
        phase(1'b0, 1'b0, 32'h2468_ACE0, 4'h3, 1'b0, 1'b1, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule